// File: doc/BRIEF.md
# SPI Master Word Shifter

This block is the bit engine of a single-lane SPI master. It fetches 32-bit words from an external transmit queue through a pop handshake. Each word is shifted out on MOSI most significant bit first. At the same time a 32-bit word is collected from MISO and handed to an external receive queue through a push strobe. Every word sent produces exactly one word received. Neither queue is stored inside the block.

A set of configuration fields is loaded together on a single write strobe. They select:
- the serial clock divider;
- clock polarity and clock phase;
- a global enable;
- a software-driven chip-select override;
- a mode in which each word waits for an explicit start request.

The block drives SCLK, MOSI and an active-low chip select, and it reports whether a word is in flight.

Top module: `spi_shift_master`

## Requirements
- R1: With divider code `cfg_div` = n (0..7), each SCLK half period lasts 2^n reference cycles, so SCLK runs at the reference clock divided by 2^(n+1); `busy` stays high for exactly 64·2^n cycles per word.
- R2: The popped `tx_data` word leaves on `mosi` most significant bit first, and a receiver sampling on the sampling edges recovers exactly that word.
- R3: Bits on `miso` are assembled most significant bit first. `rx_push` pulses for one cycle, exactly one per completed word, in the cycle after `busy` falls, and `rx_data` then holds the received word.
- R4: While idle, `sclk` rests at `cfg_cpol`. A word produces exactly 64 SCLK transitions and ends with `sclk` back at the idle level.
- R5: With `cfg_cpha`=0, MISO and MOSI are sampled on the first edge of each bit and MOSI changes on the second. With `cfg_cpha`=1 the roles swap: data changes on the first edge and is sampled on the second.
- R6: In automatic mode (`cfg_man_en`=0), a word is popped whenever the engine is idle, enabled and `tx_valid` is high. When the queue is empty the engine stays idle and drives no SCLK edges.
- R7: In manual-start mode (`cfg_man_en`=1), no word is popped until a configuration write with `cfg_man_start`=1. Each such request launches one word, and the request clears itself once that word starts.
- R8: With `cfg_cs_force`=1, `cs_n` equals `cfg_cs_level` (0 selects the device, 1 releases it) regardless of activity. Otherwise `cs_n` is 0 exactly while `busy` is 1.
- R9: With `cfg_en`=0, no word is popped. Clearing `cfg_en` during a word drops `busy` in the next cycle, returns `sclk` to the idle level, and produces no `rx_push` for the aborted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_en | input | 1 | Global enable |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_div | input | 3 | Divider code n, divide by 2^(n+1) |
| cfg_cs_force | input | 1 | Software controls chip select |
| cfg_cs_level | input | 1 | Chip-select level under override |
| cfg_man_en | input | 1 | Manual-start mode |
| cfg_man_start | input | 1 | Start request, self-clearing |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Head word of transmit queue |
| tx_pop | output | 1 | Consumes the head word |
| rx_push | output | 1 | Pushes `rx_data` into receive queue |
| rx_data | output | 32 | Word received from MISO |
| miso | input | 1 | Serial data from device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to device |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A word is being shifted |

## Verification
Faults in the divider counter or the edge counter show up as a wrong `busy` length or a missing `rx_push` within the first word. A phase or polarity fault shows up as a corrupted word at the modelled device or in `rx_data` as soon as the word completes. Faults in the start gating or enable handling show up as a `tx_pop` that should not occur, seen within a few dozen cycles of the word being offered. Every divider code is swept in every clock mode, so a fault tied to a single code or mode is still exposed.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cs_force,
  input  logic              cfg_cs_level,
  input  logic              cfg_man_en,
  input  logic              cfg_man_start,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy
);
  localparam int CNT_W  = (1 << DIV_W) - 1;
  localparam int EDGE_W = $clog2(2 * WORD_W);

  logic             en_q, cpol_q, cpha_q, frc_q, lvl_q, man_q, start_pend;
  logic [DIV_W-1:0] div_q;
  logic             busy_q, sclk_q, mosi_q, push_q;
  logic [WORD_W-1:0] out_sr, in_sr;
  logic [CNT_W-1:0]  div_cnt, half_m1;
  logic [EDGE_W-1:0] edge_cnt;
  logic tick, last, lead, sample_now;

  assign half_m1    = (CNT_W'(1) << div_q) - CNT_W'(1);
  assign tick       = busy_q && (div_cnt == half_m1);
  assign last       = tick && (edge_cnt == EDGE_W'(2 * WORD_W - 1));
  assign lead       = ~edge_cnt[0];
  assign sample_now = lead ^ cpha_q;
  assign tx_pop     = !busy_q && en_q && tx_valid && (!man_q || start_pend);

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_push = push_q;
  assign rx_data = in_sr;
  assign cs_n    = frc_q ? lvl_q : !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; div_q <= '0;
      frc_q <= 1'b0; lvl_q <= 1'b1; man_q <= 1'b0; start_pend <= 1'b0;
    end else begin
      if (cfg_we) begin
        en_q <= cfg_en; cpol_q <= cfg_cpol; cpha_q <= cfg_cpha; div_q <= cfg_div;
        frc_q <= cfg_cs_force; lvl_q <= cfg_cs_level; man_q <= cfg_man_en;
      end
      if (cfg_we && cfg_man_start) start_pend <= 1'b1;
      else if (tx_pop)             start_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0; push_q <= 1'b0;
      out_sr <= '0; in_sr <= '0; div_cnt <= '0; edge_cnt <= '0;
    end else begin
      push_q <= last && en_q;
      if (!en_q) begin
        busy_q <= 1'b0;
        sclk_q <= cpol_q;
      end else if (tx_pop) begin
        busy_q   <= 1'b1;
        sclk_q   <= cpol_q;
        div_cnt  <= '0;
        edge_cnt <= '0;
        out_sr   <= cpha_q ? tx_data : (tx_data << 1);
        if (!cpha_q) mosi_q <= tx_data[WORD_W-1];
      end else if (busy_q) begin
        div_cnt <= tick ? '0 : div_cnt + CNT_W'(1);
        if (tick) begin
          sclk_q   <= ~sclk_q;
          edge_cnt <= edge_cnt + EDGE_W'(1);
          if (sample_now) in_sr <= {in_sr[WORD_W-2:0], miso};
          else begin
            mosi_q <= out_sr[WORD_W-1];
            out_sr <= out_sr << 1;
          end
          if (last) busy_q <= 1'b0;
        end
      end else begin
        sclk_q <= cpol_q;
      end
    end
  end

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !busy_q);
  // R3
  push_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> ($past(busy_q) && !busy_q));
  // R6
  pop_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy_q);
  // R7
  manual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && man_q) |=> !start_pend || $past(cfg_we && cfg_man_start));
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_q) |-> (sclk_q == $past(cpol_q)));
endmodule

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_cs_force = 0;
  logic cfg_cs_level = 1, cfg_man_en = 0, cfg_man_start = 0;
  logic [2:0] cfg_div = 0;
  logic tx_valid, tx_pop, rx_push, miso = 0, sclk, mosi, cs_n, busy;
  logic [31:0] tx_data, rx_data;

  logic [31:0] txq [0:63];
  logic [31:0] rxq [0:63];
  logic [31:0] sl_got [0:63];
  int wr_ptr = 0, rd_ptr = 0, rx_n = 0, sl_n = 0, sclk_tog = 0;
  int n_cmp = 0, n_bad = 0;

  logic [31:0] s_word = 0, slv_sr = 0, got = 0;
  logic s_cpol = 0, s_cpha = 0, slv_arm = 0, lead;
  int ecnt = 0;

  always #5 clk = ~clk;

  assign tx_valid = rd_ptr < wr_ptr;
  assign tx_data  = txq[rd_ptr[5:0]];

  spi_shift_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .cfg_cs_force(cfg_cs_force),
    .cfg_cs_level(cfg_cs_level), .cfg_man_en(cfg_man_en), .cfg_man_start(cfg_man_start),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_data(rx_data), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy));

  always @(posedge clk) begin
    if (tx_pop) rd_ptr <= rd_ptr + 1;
    if (rx_push) begin rxq[rx_n[5:0]] <= rx_data; rx_n <= rx_n + 1; end
  end

  // device model: sample/launch per clock mode, reload after 64 edges
  always @(sclk) if (rst_n) begin
    sclk_tog = sclk_tog + 1;
    if (slv_arm) begin
      lead = (sclk != s_cpol);
      if (lead ^ s_cpha) got = {got[30:0], mosi};
      else begin miso = slv_sr[31]; slv_sr = slv_sr << 1; end
      ecnt = ecnt + 1;
      if (ecnt == 64) begin
        sl_got[sl_n[5:0]] = got; sl_n = sl_n + 1; ecnt = 0;
        if (!s_cpha) miso = s_word[31];
        slv_sr = s_cpha ? s_word : (s_word << 1);
      end
    end
  end

  task automatic slave_load(input logic [31:0] w);
    s_word = w; ecnt = 0; slv_arm = 1;
    if (!s_cpha) miso = w[31];
    slv_sr = s_cpha ? w : (w << 1);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_set(input bit en, input bit cp, input bit ch, input logic [2:0] dv,
                         input bit frc, input bit lvl, input bit man, input bit st);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_cpol = cp; cfg_cpha = ch; cfg_div = dv;
    cfg_cs_force = frc; cfg_cs_level = lvl; cfg_man_en = man; cfg_man_start = st;
    s_cpol = cp; s_cpha = ch;
    @(negedge clk); cfg_we = 0; cfg_man_start = 0;
    @(negedge clk);
  endtask

  task automatic push_word(input logic [31:0] w);
    txq[wr_ptr[5:0]] = w; wr_ptr = wr_ptr + 1;
  endtask

  task automatic wait_rx(input int target, output int busy_cyc, output int cs_bad);
    int guard = 0;
    busy_cyc = 0; cs_bad = 0;
    while (rx_n < target && guard < 40000) begin
      @(negedge clk); guard++;
      if (busy) begin busy_cyc++; if (cs_n !== 1'b0) cs_bad++; end
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int bc, cb, r0, t0;
    logic [31:0] tw, sw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset cs_n", cs_n, 1);
    check("R4 reset sclk", sclk, 0);
    check("R9 reset busy", busy, 0);
    check("R3 reset rx_push", rx_push, 0);

    // R9: disabled engine never pops
    push_word(32'hDEAD_BEEF);
    repeat (30) @(negedge clk);
    check("R9 no pop while disabled", rd_ptr, 0);
    check("R9 idle while disabled", busy, 0);
    wr_ptr = rd_ptr;

    // R1 R2 R3 R4 R5 R8: every divider code in every clock mode
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 8; d++) begin
        cfg_set(1, m[1], m[0], d[2:0], 0, 1, 0, 0);
        tw = 32'h8000_0001 ^ (32'h0123_4567 * (m * 8 + d + 1));
        sw = ~tw ^ (32'h0001_0000 << d);
        slave_load(sw);
        r0 = rx_n;
        push_word(tw);
        wait_rx(r0 + 1, bc, cb);
        check($sformatf("R1 busy length div=%0d mode=%0d", d, m), bc, 64 << d);
        check($sformatf("R2 device got mode=%0d div=%0d", m, d), sl_got[(sl_n - 1) & 63], tw);
        check($sformatf("R3 R5 rx word mode=%0d div=%0d", m, d), rxq[(rx_n - 1) & 63], sw);
        check($sformatf("R4 idle sclk mode=%0d", m), sclk, m[1]);
        check($sformatf("R8 cs low while busy mode=%0d", m), cb, 0);
      end
    end

    // R6: back-to-back words, then an empty queue
    cfg_set(1, 0, 0, 3'd0, 0, 1, 0, 0);
    slave_load(32'h5A5A_0FF0);
    r0 = rx_n; t0 = sl_n;
    for (int k = 0; k < 3; k++) push_word(32'h1111_1111 * (k + 3));
    wait_rx(r0 + 3, bc, cb);
    for (int k = 0; k < 3; k++) begin
      check("R6 burst rx", rxq[(r0 + k) & 63], 32'h5A5A_0FF0);
      check("R6 burst device", sl_got[(t0 + k) & 63], 32'h1111_1111 * (k + 3));
    end
    t0 = sclk_tog;
    repeat (50) @(negedge clk);
    check("R6 no sclk edges when empty", sclk_tog - t0, 0);
    check("R6 idle when empty", busy, 0);

    // R7: manual start
    cfg_set(1, 1, 1, 3'd1, 0, 1, 1, 0);
    slave_load(32'hC0DE_1234);
    r0 = rx_n; t0 = rd_ptr;
    push_word(32'h0BAD_F00D);
    repeat (60) @(negedge clk);
    check("R7 waits for start", rd_ptr - t0, 0);
    cfg_set(1, 1, 1, 3'd1, 0, 1, 1, 1);
    wait_rx(r0 + 1, bc, cb);
    check("R7 triggered word rx", rxq[(rx_n - 1) & 63], 32'hC0DE_1234);
    check("R7 triggered word device", sl_got[(sl_n - 1) & 63], 32'h0BAD_F00D);
    t0 = rd_ptr;
    push_word(32'h7777_0001);
    repeat (60) @(negedge clk);
    check("R7 start self-clears", rd_ptr - t0, 0);
    r0 = rx_n;
    cfg_set(1, 1, 1, 3'd1, 0, 1, 1, 1);
    wait_rx(r0 + 1, bc, cb);
    check("R7 second trigger", sl_got[(sl_n - 1) & 63], 32'h7777_0001);

    // R8: chip-select override
    cfg_set(1, 0, 0, 3'd0, 1, 0, 0, 0);
    check("R8 forced select while idle", cs_n, 0);
    cfg_set(1, 0, 0, 3'd0, 1, 1, 0, 0);
    slave_load(32'h0);
    r0 = rx_n;
    push_word(32'h2468_ACE0);
    repeat (10) @(negedge clk);
    check("R8 forced release while busy", {busy, cs_n}, 2'b11);
    wait_rx(r0 + 1, bc, cb);
    cfg_set(1, 0, 0, 3'd0, 0, 1, 0, 0);
    check("R8 auto cs idle", cs_n, 1);

    // R9: abort mid-word
    cfg_set(1, 1, 0, 3'd7, 0, 1, 0, 0);
    slave_load(32'h1357_9BDF);
    r0 = rx_n;
    push_word(32'hFEDC_BA98);
    repeat (300) @(negedge clk);
    check("R9 busy before abort", busy, 1);
    cfg_set(0, 1, 0, 3'd7, 0, 1, 0, 0);
    check("R9 abort busy", busy, 0);
    check("R9 abort sclk idle", sclk, 1);
    repeat (50) @(negedge clk);
    check("R9 no push after abort", rx_n - r0, 0);

    finish_run();
  end
endmodule